// File: doc/BRIEF.md
# Raster Frame Timing Counter

This block produces the beam position of a video timing generator. It advances by one dot on every pixel clock. The frame is 341 dots wide and 262 lines tall. The block also keeps a flag that tells even frames from odd ones, and it decodes three single-cycle strobes from the position: frame start, vertical-blank start and pre-render line start. Downstream fetch, palette and register logic use these outputs to schedule their work. That logic is not part of this block.

Lines 0 to 239 are visible. Line 240 is the post-render line, lines 241 to 260 are vertical blank, and line 261 is the pre-render line. A four-state phase machine follows these regions:

- `PH_VISIBLE` goes to `PH_POSTRENDER` at the end of the last visible line.
- `PH_POSTRENDER` goes to `PH_VBLANK` at the end of its only line.
- `PH_VBLANK` goes to `PH_PRERENDER` at the end of line 260.
- `PH_PRERENDER` goes back to `PH_VISIBLE` when the frame wraps.

The frame can wrap in two ways. Normally it wraps at the last dot of line 261. On an odd frame, if rendering is enabled on the clock where the position is dot 339 of line 261, the counter jumps straight to dot 0 of line 0. That odd frame is one dot shorter. The enable input is looked at only on that clock, so enabling rendering later in the frame still gives a full-length frame.

Top module: `raster_timing_gen`

## Requirements
- R1: The dot output counts 0 to 340 on successive clocks. After dot 340 it returns to 0, and the line output advances by one.
- R2: The line output runs from 0 to 261. Line 261 is the pre-render line and is followed by line 0. A frame without a skip is 89342 clocks long.
- R3: The odd-frame output (1 = odd) inverts once at the end of every frame, whether rendering is enabled or not.
- R4: If `render_en` is low on the clock at dot 339 of line 261, that clock is followed by dot 340 of line 261. With rendering always off, every frame is 89342 clocks.
- R5: If the odd-frame output is 1 and `render_en` is high on the clock at dot 339 of line 261, the next position is dot 0 of line 0. That odd frame is 89341 clocks, and an even frame plus the following odd frame is 178683 clocks.
- R6: `render_en` has no effect on any clock other than the one at dot 339 of line 261. Raising it just after that clock gives a full-length frame.
- R7: `frame_start_o` is high exactly on the clocks where the position is dot 0, line 0.
- R8: `vblank_start_o` is high for exactly one clock per frame, at dot 1 of line 241.
- R9: `prerender_start_o` is high for exactly one clock per frame, at dot 1 of line 261. This is 6820 clocks after the vertical-blank strobe.
- R10: While synchronous active-high `rst` is high, the position is held at dot 0, line 0 and the odd-frame output is 0. The first frame after reset is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| render_en | input | 1 | Background rendering enabled |
| dot_o | output | 9 | Current dot within the line |
| line_o | output | 9 | Current line within the frame |
| odd_frame_o | output | 1 | 1 during odd frames |
| frame_start_o | output | 1 | High at dot 0 of line 0 |
| vblank_start_o | output | 1 | High at dot 1 of line 241 |
| prerender_start_o | output | 1 | High at dot 1 of line 261 |

## Verification
The assertions place no limits on `render_en`. It may change on any clock, and the properties cover both the high and the low case at the skip point. The only assumption is that `rst` is released synchronously, because every property is disabled while reset is high.

The stimulus drives `render_en` in five ways:
- held low;
- held high;
- high except at the skip clock;
- low except at the skip clock;
- random on every clock.

This reaches both the taken and the refused skip on odd frames. A smaller instance of the block makes many frames fit in a short run.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic [1:0] {
        PH_VISIBLE,
        PH_POSTRENDER,
        PH_VBLANK,
        PH_PRERENDER
    } raster_phase_e;
endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
    parameter int DOTS_PER_LINE = 341,
    localparam int DOT_W = $clog2(DOTS_PER_LINE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             skip_i,
    output logic [DOT_W-1:0] dot_o,
    output logic             wrap_o
);
    localparam logic [DOT_W-1:0] LAST_DOT = DOT_W'(DOTS_PER_LINE - 1);

    logic [DOT_W-1:0] dot_q;

    // Wrap at the last dot, or early when the odd-frame skip fires
    assign wrap_o = (dot_q == LAST_DOT) || skip_i;

    always_ff @(posedge clk) begin
        if (rst)
            dot_q <= '0;
        else if (wrap_o)
            dot_q <= '0;
        else
            dot_q <= dot_q + 1'b1;
    end

    assign dot_o = dot_q;
endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr #(
    parameter int LINES_PER_FRAME = 262,
    localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [LINE_W-1:0] line_o,
    output logic              last_o
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);

    logic [LINE_W-1:0] line_q;

    assign last_o = (line_q == LAST_LINE);

    always_ff @(posedge clk) begin
        if (rst)
            line_q <= '0;
        else if (step_i)
            line_q <= last_o ? '0 : line_q + 1'b1;
    end

    assign line_o = line_q;
endmodule

// File: rtl/raster_phase_fsm.sv
module raster_phase_fsm
    import raster_pkg::*;
#(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VBLANK_LINE     = 241,
    localparam int DOT_W  = $clog2(DOTS_PER_LINE),
    localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_step_i,
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              odd_i,
    input  logic              render_en_i,
    output logic              skip_o,
    output logic              frame_start_o,
    output logic              vblank_start_o,
    output logic              prerender_start_o
);
    localparam logic [LINE_W-1:0] LAST_VIS_LINE = LINE_W'(VBLANK_LINE - 2);
    localparam logic [LINE_W-1:0] LAST_VBL_LINE = LINE_W'(LINES_PER_FRAME - 2);
    localparam logic [LINE_W-1:0] VBL_LINE      = LINE_W'(VBLANK_LINE);
    localparam logic [DOT_W-1:0]  SKIP_DOT      = DOT_W'(DOTS_PER_LINE - 2);
    localparam logic [DOT_W-1:0]  STROBE_DOT    = DOT_W'(1);

    raster_phase_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PH_VISIBLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_VISIBLE:    if (line_step_i && line_i == LAST_VIS_LINE) state_d = PH_POSTRENDER;
            PH_POSTRENDER: if (line_step_i) state_d = PH_VBLANK;
            PH_VBLANK:     if (line_step_i && line_i == LAST_VBL_LINE) state_d = PH_PRERENDER;
            PH_PRERENDER:  if (line_step_i) state_d = PH_VISIBLE;
        endcase
    end

    // Outputs decoded from phase and dot position
    always_comb begin
        skip_o            = 1'b0;
        frame_start_o     = 1'b0;
        vblank_start_o    = 1'b0;
        prerender_start_o = 1'b0;
        unique case (state_q)
            PH_VISIBLE:    frame_start_o  = (line_i == '0) && (dot_i == '0);
            PH_POSTRENDER: ;
            PH_VBLANK:     vblank_start_o = (line_i == VBL_LINE) && (dot_i == STROBE_DOT);
            PH_PRERENDER: begin
                prerender_start_o = (dot_i == STROBE_DOT);
                skip_o            = (dot_i == SKIP_DOT) && odd_i && render_en_i;
            end
        endcase
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VBLANK_LINE     = 241
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 render_en,
    output logic [$clog2(DOTS_PER_LINE)-1:0]     dot_o,
    output logic [$clog2(LINES_PER_FRAME)-1:0]   line_o,
    output logic                                 odd_frame_o,
    output logic                                 frame_start_o,
    output logic                                 vblank_start_o,
    output logic                                 prerender_start_o
);
    localparam int DOT_W  = $clog2(DOTS_PER_LINE);
    localparam int LINE_W = $clog2(LINES_PER_FRAME);

    logic              skip;
    logic              dot_wrap;
    logic              line_last;
    logic              odd_q;
    logic [DOT_W-1:0]  dot;
    logic [LINE_W-1:0] line;

    raster_dot_ctr #(.DOTS_PER_LINE(DOTS_PER_LINE)) u_dot (
        .clk    (clk),
        .rst    (rst),
        .skip_i (skip),
        .dot_o  (dot),
        .wrap_o (dot_wrap)
    );

    raster_line_ctr #(.LINES_PER_FRAME(LINES_PER_FRAME)) u_line (
        .clk    (clk),
        .rst    (rst),
        .step_i (dot_wrap),
        .line_o (line),
        .last_o (line_last)
    );

    raster_phase_fsm #(
        .DOTS_PER_LINE   (DOTS_PER_LINE),
        .LINES_PER_FRAME (LINES_PER_FRAME),
        .VBLANK_LINE     (VBLANK_LINE)
    ) u_fsm (
        .clk               (clk),
        .rst               (rst),
        .line_step_i       (dot_wrap),
        .dot_i             (dot),
        .line_i            (line),
        .odd_i             (odd_q),
        .render_en_i       (render_en),
        .skip_o            (skip),
        .frame_start_o     (frame_start_o),
        .vblank_start_o    (vblank_start_o),
        .prerender_start_o (prerender_start_o)
    );

    // Frame parity flips on every frame wrap
    always_ff @(posedge clk) begin
        if (rst)
            odd_q <= 1'b0;
        else if (dot_wrap && line_last)
            odd_q <= ~odd_q;
    end

    assign dot_o       = dot;
    assign line_o      = line;
    assign odd_frame_o = odd_q;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VBLANK_LINE     = 241,
    localparam int DOT_W  = $clog2(DOTS_PER_LINE),
    localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
    input logic              clk,
    input logic              rst,
    input logic              render_en,
    input logic [DOT_W-1:0]  dot_o,
    input logic [LINE_W-1:0] line_o,
    input logic              odd_frame_o,
    input logic              frame_start_o,
    input logic              vblank_start_o,
    input logic              prerender_start_o
);
    localparam logic [DOT_W-1:0]  LAST_DOT = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [DOT_W-1:0]  SKIP_DOT = DOT_W'(DOTS_PER_LINE - 2);
    localparam logic [LINE_W-1:0] PRE_LINE = LINE_W'(LINES_PER_FRAME - 1);

    AST_DOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        dot_o <= LAST_DOT); // R1

    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (dot_o == LAST_DOT && line_o != PRE_LINE) |=> (dot_o == '0 && line_o == $past(line_o) + 1'b1)); // R1

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (dot_o == LAST_DOT && line_o == PRE_LINE) |=> (dot_o == '0 && line_o == '0)); // R2

    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (rst)
        (frame_start_o && dot_o == '0 && $past(line_o) == PRE_LINE) |-> (odd_frame_o != $past(odd_frame_o))); // R3

    AST_NO_SKIP_OFF: assert property (@(posedge clk) disable iff (rst)
        (dot_o == SKIP_DOT && line_o == PRE_LINE && !render_en) |=> (dot_o == LAST_DOT)); // R4

    AST_SKIP_ODD: assert property (@(posedge clk) disable iff (rst)
        (dot_o == SKIP_DOT && line_o == PRE_LINE && render_en && odd_frame_o) |=> (dot_o == '0 && line_o == '0)); // R5

    AST_NO_SKIP_EVEN: assert property (@(posedge clk) disable iff (rst)
        (dot_o == SKIP_DOT && line_o == PRE_LINE && !odd_frame_o) |=> (dot_o == LAST_DOT)); // R6

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_start_o, vblank_start_o, prerender_start_o})); // R7

    AST_VBL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        vblank_start_o |=> !vblank_start_o); // R8

    AST_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        prerender_start_o |=> !prerender_start_o); // R9

    AST_PARITY_STEADY: assert property (@(posedge clk) disable iff (rst)
        !(dot_o == '0 && line_o == '0) |-> $stable(odd_frame_o)); // R3
endmodule

bind raster_timing_gen raster_timing_chk #(
    .DOTS_PER_LINE   (DOTS_PER_LINE),
    .LINES_PER_FRAME (LINES_PER_FRAME),
    .VBLANK_LINE     (VBLANK_LINE)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .render_en         (render_en),
    .dot_o             (dot_o),
    .line_o            (line_o),
    .odd_frame_o       (odd_frame_o),
    .frame_start_o     (frame_start_o),
    .vblank_start_o    (vblank_start_o),
    .prerender_start_o (prerender_start_o)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
    // Small instance geometry
    localparam int SD = 12;
    localparam int SL = 10;
    localparam int SV = 7;
    localparam int SN = SD * SL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ren_big = 1'b1;
    logic ren_small = 1'b0;

    logic [8:0] b_dot, b_line;
    logic       b_odd, b_fs, b_vb, b_pr;
    logic [3:0] s_dot, s_line;
    logic       s_odd, s_fs, s_vb, s_pr;

    int tests = 0;
    int fails = 0;
    bit big_done = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    raster_timing_gen uut (
        .clk (clk), .rst (rst), .render_en (ren_big),
        .dot_o (b_dot), .line_o (b_line), .odd_frame_o (b_odd),
        .frame_start_o (b_fs), .vblank_start_o (b_vb), .prerender_start_o (b_pr)
    );

    raster_timing_gen #(.DOTS_PER_LINE(SD), .LINES_PER_FRAME(SL), .VBLANK_LINE(SV)) uut_small (
        .clk (clk), .rst (rst), .render_en (ren_small),
        .dot_o (s_dot), .line_o (s_line), .odd_frame_o (s_odd),
        .frame_start_o (s_fs), .vblank_start_o (s_vb), .prerender_start_o (s_pr)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Reference position model for the small geometry
    typedef struct { int dot; int line; int odd; } pos_t;

    function automatic pos_t step(pos_t p, bit ren);
        pos_t n = p;
        if (p.line == SL - 1 && p.dot == SD - 2 && p.odd == 1 && ren) begin
            n.dot = 0; n.line = 0; n.odd = 0;
        end else if (p.dot == SD - 1) begin
            n.dot = 0;
            if (p.line == SL - 1) begin n.line = 0; n.odd = 1 - p.odd; end
            else n.line = p.line + 1;
        end else n.dot = p.dot + 1;
        return n;
    endfunction

    // Expected small frame length for the directed frames 0..11
    function automatic int exp_len(int i);
        if (i < 4) return SN;                 // rendering off
        if (i < 8) return (i % 2) ? SN - 1 : SN; // rendering on
        if (i < 10) return SN;                // enable dropped at skip clock only
        return (i % 2) ? SN - 1 : SN;         // enable raised at skip clock only
    endfunction

    task automatic run_big();
        int cyc = 0, nfs = 0, s0 = 0, s1 = 0, vb_at = -1;
        bit vb_checked = 0;
        while (nfs < 3) begin
            if (b_fs) begin
                check("R7", "frame start dot", int'(b_dot), 0);
                check("R7", "frame start line", int'(b_line), 0);
                if (nfs == 0) begin
                    s0 = cyc;
                    check("R10", "first frame parity", int'(b_odd), 0);
                end else if (nfs == 1) begin
                    s1 = cyc;
                    check("R2", "even frame length", s1 - s0, 89342);
                    check("R3", "parity after even frame", int'(b_odd), 1);
                end else begin
                    check("R5", "odd frame length", cyc - s1, 89341);
                    check("R5", "even plus odd length", cyc - s0, 178683);
                    check("R3", "parity after odd frame", int'(b_odd), 0);
                end
                nfs++;
            end
            if (b_vb) begin
                vb_at = cyc;
                check("R8", "vblank strobe line", int'(b_line), 241);
                check("R8", "vblank strobe dot", int'(b_dot), 1);
            end
            if (b_pr && vb_at >= 0 && !vb_checked) begin
                vb_checked = 1;
                check("R9", "pre-render line", int'(b_line), 261);
                check("R9", "vblank to pre-render gap", cyc - vb_at, 6820);
            end
            if (nfs < 3) begin @(negedge clk); cyc++; end
        end
        big_done = 1'b1;
    endtask

    task automatic run_small();
        pos_t m = '{0, 0, 0};
        int cyc = 0, nfs = 0, prev = 0, vbs = 0, prs = 0;
        bit at_skip, r;
        while (!big_done) begin
            check("R1", "small dot", int'(s_dot), m.dot);
            check("R2", "small line", int'(s_line), m.line);
            check("R3", "small parity", int'(s_odd), m.odd);
            check("R7", "small frame start", int'(s_fs), (m.dot == 0 && m.line == 0) ? 1 : 0);
            check("R8", "small vblank strobe", int'(s_vb), (m.dot == 1 && m.line == SV) ? 1 : 0);
            check("R9", "small pre-render strobe", int'(s_pr), (m.dot == 1 && m.line == SL - 1) ? 1 : 0);
            if (s_vb) vbs++;
            if (s_pr) prs++;
            if (s_fs) begin
                if (nfs > 0 && nfs <= 12) begin
                    case (nfs - 1)
                        0, 1, 2, 3: check("R4", "small frame length, rendering off", cyc - prev, exp_len(nfs - 1));
                        8, 9:       check("R6", "small frame length, late enable", cyc - prev, exp_len(nfs - 1));
                        10, 11:     check("R6", "small frame length, enable at skip only", cyc - prev, exp_len(nfs - 1));
                        default:    check("R5", "small frame length, rendering on", cyc - prev, exp_len(nfs - 1));
                    endcase
                end
                if (nfs > 0) begin
                    check("R8", "vblank strobes per frame", vbs, 1);
                    check("R9", "pre-render strobes per frame", prs, 1);
                end
                vbs = 0; prs = 0;
                prev = cyc;
                nfs++;
            end
            at_skip = (m.line == SL - 1 && m.dot == SD - 2);
            if (nfs <= 4)       r = 1'b0;
            else if (nfs <= 8)  r = 1'b1;
            else if (nfs <= 10) r = !at_skip;
            else if (nfs <= 12) r = at_skip;
            else                r = 1'($urandom() & 1);
            ren_small = r;
            m = step(m, r);
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = int'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R10: reset holds the origin and clears parity, even with rendering on
        check("R10", "reset dot", int'(b_dot), 0);
        check("R10", "reset line", int'(b_line), 0);
        check("R10", "reset parity", int'(b_odd), 0);
        check("R10", "reset small dot", int'(s_dot), 0);
        rst = 1'b0;
        fork
            run_big();
            run_small();
        join
        summary();
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule